// File: doc/BRIEF.md
# Shuffle-Exchange Next-Hop Router

This block makes the routing decision for one node of a shuffle-exchange interconnect with 2^K nodes, addressed 0 to 2^K − 1. Each node has two outgoing links. The shuffle link goes to the node whose address is the current one rotated left by one bit. The exchange link goes to the node whose address differs only in bit 0. A packet carries a small step counter. On each request the router takes the current node address, the packet's destination and that counter. One clock later it returns the link to use next (or local delivery) and the counter value the packet should carry onward. It also returns both neighbour addresses of the current node.

The route settles destination bits from the most significant down to the least. In the opening round only an exchange may happen, with no shuffle. Each later round takes a shuffle and then, if bit 0 of the address disagrees with the destination bit for that round, an exchange. The counter is even while an exchange decision is pending and odd while a shuffle is pending. Leaving out the opening shuffle bounds any route at 2K − 1 hops. Flow control, buffering and transport of the packet lie outside the block.

Top module: `se_hop_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid`, `out_port`, `out_step`, `shuf_nbr` and `exch_nbr` all at zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the other outputs then describe that request.
- R3: `shuf_nbr` is `cur_addr` rotated left by one bit: bit K−1 moves to bit 0.
- R4: `exch_nbr` is `cur_addr` with only bit 0 inverted.
- R5: If `cur_addr` equals `dst_addr`, `out_port` is 2'b00 (deliver locally) and `out_step` equals `step_in`, whatever the step value.
- R6: If not arrived, `step_in` = s is even, s ≤ 2K−2, and `cur_addr[0]` differs from `dst_addr[K−1−s/2]`, then `out_port` is 2'b10 (exchange) and `out_step` is s+1.
- R7: If not arrived, s is even, s ≤ 2K−2, and `cur_addr[0]` equals `dst_addr[K−1−s/2]`, then `out_port` is 2'b01 (shuffle) and `out_step` is s+2.
- R8: If not arrived, s is odd and s ≤ 2K−2, then `out_port` is 2'b01 (shuffle) and `out_step` is s+1.
- R9: If not arrived and s > 2K−2, then `out_port` is 2'b11 (fault) and `out_step` equals s.
- R10: A packet that starts at step 0 and follows the chosen links reaches every destination from every source in at most 2K−1 hops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A routing request is present |
| cur_addr | input | K | Address of the node holding the packet |
| dst_addr | input | K | Destination node address |
| step_in | input | STEP_W | Step counter carried by the packet |
| out_valid | output | 1 | Result of the previous cycle's request |
| out_port | output | 2 | 00 local, 01 shuffle, 10 exchange, 11 fault |
| out_step | output | STEP_W | Counter value for the next hop |
| shuf_nbr | output | K | Shuffle neighbour of the requested node |
| exch_nbr | output | K | Exchange neighbour of the requested node |

## Verification
The bench drives requests where the step is even and bit 0 of the address matches the destination bit. A router that stalls there would send a needless exchange. One that skips without shuffling would never converge, and the full walk would catch it as a missed arrival or an overlong path. Requests with the address already at the destination but a large or fault-range counter show whether arrival takes priority over the fault code. Walking every source and destination pair for K = 3 and K = 4 exposes a wrong bit index or rotation direction: such a design delivers to the wrong node or goes past 2K−1 hops. The bench also checks the neighbour outputs against independently computed rotations, and checks that the output registers clear under reset.

// File: rtl/se_route_pkg.sv
package se_route_pkg;
  typedef enum logic [1:0] {
    PORT_LOCAL = 2'b00,
    PORT_SHUF  = 2'b01,
    PORT_EXCH  = 2'b10,
    PORT_FAULT = 2'b11
  } port_e;
endpackage

// File: rtl/se_nbr_calc.sv
module se_nbr_calc #(
  parameter int K = 4
) (
  input  logic [K-1:0] node,
  output logic [K-1:0] shuf,
  output logic [K-1:0] exch
);
  // rotate left by one: bit i takes bit i-1, bit 0 takes the top bit
  for (genvar i = 0; i < K; i++) begin : g_rot
    if (i == 0) begin : g_wrap
      assign shuf[0] = node[K-1];
    end else begin : g_mid
      assign shuf[i] = node[i-1];
    end
  end

  assign exch = {node[K-1:1], ~node[0]};
endmodule

// File: rtl/se_step_decide.sv
module se_step_decide
  import se_route_pkg::*;
#(
  parameter int K      = 4,
  parameter int STEP_W = $clog2(2*K+1)
) (
  input  logic [K-1:0]      node,
  input  logic [K-1:0]      dest,
  input  logic [STEP_W-1:0] step,
  output port_e             port,
  output logic [STEP_W-1:0] step_nxt
);
  localparam int LAST = 2*K - 2;

  logic want_bit;
  logic at_dest;
  logic in_range;

  // destination bit for the current round: round r = step/2 settles bit K-1-r
  always_comb begin
    want_bit = 1'b0;
    for (int r = 0; r < K; r++) begin
      if (int'(step >> 1) == r) want_bit = dest[K-1-r];
    end
  end

  assign at_dest  = (node == dest);
  assign in_range = (int'(step) <= LAST);

  always_comb begin
    port     = PORT_LOCAL;
    step_nxt = step;
    if (at_dest) begin
      port     = PORT_LOCAL;
      step_nxt = step;
    end else if (!in_range) begin
      port     = PORT_FAULT;
      step_nxt = step;
    end else if (step[0]) begin
      port     = PORT_SHUF;
      step_nxt = step + STEP_W'(1);
    end else if (node[0] != want_bit) begin
      port     = PORT_EXCH;
      step_nxt = step + STEP_W'(1);
    end else begin
      port     = PORT_SHUF;
      step_nxt = step + STEP_W'(2);
    end
  end
endmodule

// File: rtl/se_hop_router.sv
module se_hop_router
  import se_route_pkg::*;
#(
  parameter int K      = 4,
  parameter int STEP_W = $clog2(2*K+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [K-1:0]      cur_addr,
  input  logic [K-1:0]      dst_addr,
  input  logic [STEP_W-1:0] step_in,
  output logic              out_valid,
  output logic [1:0]        out_port,
  output logic [STEP_W-1:0] out_step,
  output logic [K-1:0]      shuf_nbr,
  output logic [K-1:0]      exch_nbr
);
  localparam int LAST = 2*K - 2;

  logic [K-1:0]      shuf_c;
  logic [K-1:0]      exch_c;
  port_e             port_c;
  logic [STEP_W-1:0] step_c;

  se_nbr_calc #(.K(K)) u_nbr (
    .node (cur_addr),
    .shuf (shuf_c),
    .exch (exch_c)
  );

  se_step_decide #(.K(K), .STEP_W(STEP_W)) u_dec (
    .node     (cur_addr),
    .dest     (dst_addr),
    .step     (step_in),
    .port     (port_c),
    .step_nxt (step_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= 2'b00;
      out_step  <= '0;
      shuf_nbr  <= '0;
      exch_nbr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port <= port_c;
        out_step <= step_c;
        shuf_nbr <= shuf_c;
        exch_nbr <= exch_c;
      end
    end
  end

  // R2: one-cycle valid pipeline
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3: rotating the registered neighbour right recovers the request address
  p_shuf_rotation_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> {shuf_nbr[0], shuf_nbr[K-1:1]} == $past(cur_addr));
  // R4: exchange neighbour differs from the request in bit 0 only
  p_exch_flip_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (exch_nbr ^ $past(cur_addr)) == K'(1));
  // R5: local delivery only when the request was already at its destination
  p_local_on_arrival_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == PORT_LOCAL) |-> $past(cur_addr) == $past(dst_addr));
  // R6: an exchange always leaves a shuffle pending (odd step)
  p_exch_odd_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == PORT_EXCH) |-> out_step[0]);
  // R7, R8: a shuffle always leaves an exchange decision pending (even step)
  p_shuf_even_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == PORT_SHUF) |-> !out_step[0]);
  // R9: fault only for an out-of-range counter, which is passed through
  p_fault_range_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_port == PORT_FAULT) |->
      (int'($past(step_in)) > LAST) && out_step == $past(step_in));
  // R10: an in-range request that has not arrived makes progress
  p_progress_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_addr != dst_addr && int'(step_in) <= LAST) |=>
      (out_port != PORT_LOCAL) && (out_port != PORT_FAULT) && (out_step > $past(step_in)));
endmodule

// File: tb/sim_se_hop_router.sv
module sim_se_hop_router;
  localparam int KA = 4;
  localparam int KB = 3;
  localparam int SWA = $clog2(2*KA+1);
  localparam int SWB = $clog2(2*KB+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           va, vb;
  logic [KA-1:0]  ca, da;
  logic [SWA-1:0] sa;
  logic [KB-1:0]  cb, db;
  logic [SWB-1:0] sb;
  logic           ova, ovb;
  logic [1:0]     pa, pb;
  logic [SWA-1:0] osa;
  logic [SWB-1:0] osb;
  logic [KA-1:0]  sha, exa;
  logic [KB-1:0]  shb, exb;

  se_hop_router #(.K(KA)) u0 (
    .clk(clk), .rst(rst), .in_valid(va), .cur_addr(ca), .dst_addr(da), .step_in(sa),
    .out_valid(ova), .out_port(pa), .out_step(osa), .shuf_nbr(sha), .exch_nbr(exa));

  se_hop_router #(.K(KB)) u1 (
    .clk(clk), .rst(rst), .in_valid(vb), .cur_addr(cb), .dst_addr(db), .step_in(sb),
    .out_valid(ovb), .out_port(pb), .out_step(osb), .shuf_nbr(shb), .exch_nbr(exb));

  int errors = 0;
  int checks = 0;

  // {cur, dst, step, expected port, expected step} for K = 4
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {4'd5,  4'd5,  4'd3,  2'd0, 4'd3},   // R5
    {4'd0,  4'd8,  4'd0,  2'd2, 4'd1},   // R6
    {4'd1,  4'd8,  4'd0,  2'd1, 4'd2},   // R7
    {4'd3,  4'd12, 4'd1,  2'd1, 4'd2},   // R8
    {4'd6,  4'd4,  4'd2,  2'd2, 4'd3},   // R6
    {4'd7,  4'd2,  4'd4,  2'd1, 4'd6},   // R7
    {4'd2,  4'd9,  4'd6,  2'd2, 4'd7},   // R6
    {4'd4,  4'd1,  4'd9,  2'd3, 4'd9},   // R9
    {4'd9,  4'd9,  4'd15, 2'd0, 4'd15},  // R5 over fault
    {4'd14, 4'd3,  4'd5,  2'd1, 4'd6}    // R8
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rotl(input int v, input int k);
    return ((v * 2) % (1 << k)) + (v / (1 << (k - 1)));
  endfunction

  task automatic do_hop(input int k, input int c, input int d, input int s,
                        output int port, output int nstep, output int shn, output int exn);
    @(negedge clk);
    if (k == KA) begin
      va = 1'b1; ca = KA'(c); da = KA'(d); sa = SWA'(s);
    end else begin
      vb = 1'b1; cb = KB'(c); db = KB'(d); sb = SWB'(s);
    end
    @(negedge clk);
    va = 1'b0; vb = 1'b0;
    if (k == KA) begin
      port = int'(pa); nstep = int'(osa); shn = int'(sha); exn = int'(exa);
    end else begin
      port = int'(pb); nstep = int'(osb); shn = int'(shb); exn = int'(exb);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int port, nstep, shn, exn;
    va = 1'b0; vb = 1'b0;
    ca = '1; da = '0; sa = '1; cb = '1; db = '0; sb = '1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(ova), 0);
    check("R1 out_port", int'(pa), 0);
    check("R1 out_step", int'(osa), 0);
    check("R1 shuf_nbr", int'(sha), 0);
    check("R1 exch_nbr", int'(exa), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle out_valid", int'(ova), 0);

    // table walk for K = 4
    for (int i = 0; i < NV; i++) begin
      int c, d, s, ep, es;
      c  = int'(VEC[i][17:14]);
      d  = int'(VEC[i][13:10]);
      s  = int'(VEC[i][9:6]);
      ep = int'(VEC[i][5:4]);
      es = int'(VEC[i][3:0]);
      do_hop(KA, c, d, s, port, nstep, shn, exn);
      check("R2 out_valid", int'(ova), 1);
      check("R5-R9 port", port, ep);
      check("R5-R9 step", nstep, es);
      check("R3 shuffle neighbour", shn, rotl(c, KA));
      check("R4 exchange neighbour", exn, c ^ 1);
    end
    @(negedge clk);
    check("R2 valid drops", int'(ova), 0);

    // directed corners for K = 3
    do_hop(KB, 0, 7, 0, port, nstep, shn, exn);
    check("R6 k3 first exchange", port, 2);
    check("R6 k3 step", nstep, 1);
    do_hop(KB, 5, 2, 4, port, nstep, shn, exn);   // dst bit0=0, cur0=1
    check("R6 k3 last round", port, 2);
    do_hop(KB, 4, 1, 4, port, nstep, shn, exn);   // dst bit0=1, cur0=0
    check("R6 k3 mismatch", port, 2);
    do_hop(KB, 3, 1, 6, port, nstep, shn, exn);
    check("R9 k3 fault", port, 3);
    check("R9 k3 step held", nstep, 6);
    do_hop(KB, 6, 6, 7, port, nstep, shn, exn);
    check("R5 k3 arrival", port, 0);
    do_hop(KB, 4, 0, 0, port, nstep, shn, exn);
    check("R3 k3 wrap", shn, 1);
    check("R7 k3 match", port, 1);
    check("R7 k3 step", nstep, 2);

    // R10: every source/destination pair for both sizes
    for (int sel = 0; sel < 2; sel++) begin
      int k;
      k = (sel == 0) ? KB : KA;
      for (int src = 0; src < (1 << k); src++) begin
        for (int dst = 0; dst < (1 << k); dst++) begin
          int cur, step, hops;
          bit arrived, bad;
          cur = src; step = 0; hops = 0; arrived = 1'b0; bad = 1'b0;
          for (int it = 0; it < 4 * k && !arrived && !bad; it++) begin
            do_hop(k, cur, dst, step, port, nstep, shn, exn);
            if (port == 0) arrived = 1'b1;
            else if (port == 1) begin cur = rotl(cur, k); hops++; end
            else if (port == 2) begin cur = cur ^ 1; hops++; end
            else bad = 1'b1;
            step = nstep;
          end
          check("R10 arrival", int'(arrived && cur == dst), 1);
          check("R10 hop bound", int'(hops <= 2 * k - 1), 1);
        end
      end
    end

    finish_run();
  end
endmodule